// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block steers a processor into its trap handler. The processor can issue one instruction per cycle or a dual pair made of a floating-point half and a core half. Each cycle it looks at a set of fault and request lines: instruction trap, instruction-fetch access fault, data access fault, floating-point fault, external interrupt, parity error and bus error. When at least one of them qualifies, it takes a trap. Taking a trap does four things. It overwrites the cause fields with every condition that qualified in that cycle. It records the faulting instruction address and the issue-mode flags. It pulses a pipeline flush for one cycle. It raises a fetch redirect to the fixed handler vector and holds it until the fetch unit acknowledges it.

Parity and bus error causes are held in sticky latches. While a latch is set, it masks any further trap of that kind. Software releases a latch through a clear strobe. Leaving reset performs the same redirect with every cause bit at zero, and that is how the handler tells reset apart from a real trap.

Top module: `trap_entry_ctrl`

## Requirements
- R1: One cycle after reset is released, `redirect_req` and `flush` are 1 and `redirect_pc` is 0xFFFFFF00. `core_cause`, `ext_cause`, `dim`, `ds` and `bus_in_super` are all 0 at that point.
- R2: If a trap condition qualifies at a clock edge while no redirect is pending, the next cycle shows `flush` = 1 and `redirect_req` = 1 with `redirect_pc` = 0xFFFFFF00. `flush` is 0 again in the cycle after that.
- R3: `redirect_req` stays high until `redirect_ack` is sampled high. It is low in the cycle after that edge.
- R4: While a redirect is pending, including the one that follows reset, every fault input is ignored. No flush occurs and the recorded causes and addresses do not change.
- R5: `fir` receives `cur_pc` at the trap. In single mode its two low bits are cleared. In dual mode its three low bits are cleared, which gives the address of the floating-point half; the core half is at `fir`+4.
- R6: At a trap, `dim` takes the value of `dual_mode` and `ds` takes the value of `mode_change`.
- R7: `core_cause` bit 0 = instruction trap, bit 1 = external (interrupt, parity or bus error), bit 2 = fetch access fault, bit 3 = data access fault, bit 4 = floating-point fault. At each trap every bit whose condition qualified is set together and every other bit is cleared.
- R8: `irq` qualifies only while `irq_en` is 1. It sets `core_cause[1]` and `ext_cause[0]`, and `ext_cause[0]` is cleared by any trap without an interrupt.
- R9: `par_err` qualifies only when `par_en` is 1 and `ext_cause[1]` is 0. It sets `ext_cause[1]` (sticky) and `core_cause[1]`.
- R10: `bus_err` qualifies only when `ext_cause[2]` is 0. It sets `ext_cause[2]` (sticky) and `core_cause[1]`.
- R11: At a trap, `bus_in_super` = `supervisor` AND (parity or bus error qualified).
- R12: A cycle with `clr_wr` = 1 clears `ext_cause[1]` if `clr_sel[0]` is 1 and clears `ext_cause[2]` if `clr_sel[1]` is 1. After the clear, the matching error traps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_instr | input | 1 | Instruction trap request |
| flt_fetch | input | 1 | Instruction-fetch access fault |
| flt_data | input | 1 | Data access fault |
| flt_fp | input | 1 | Floating-point fault |
| irq | input | 1 | External interrupt |
| irq_en | input | 1 | Interrupt enable |
| par_err | input | 1 | Parity error on a bus read |
| par_en | input | 1 | Parity checking enable |
| bus_err | input | 1 | Bus error |
| dual_mode | input | 1 | Processor currently in dual-issue mode |
| mode_change | input | 1 | Next instruction switches issue mode |
| supervisor | input | 1 | Processor at supervisor level |
| cur_pc | input | ADDR_W | Address of the current instruction |
| clr_wr | input | 1 | Software clear strobe |
| clr_sel | input | 2 | Latch select: bit 0 parity, bit 1 bus |
| redirect_ack | input | 1 | Fetch unit accepted the redirect |
| redirect_req | output | 1 | Fetch redirect pending |
| redirect_pc | output | ADDR_W | Handler vector |
| flush | output | 1 | One-cycle pipeline flush |
| fir | output | ADDR_W | Fault instruction address |
| dim | output | 1 | Trap taken in dual mode |
| ds | output | 1 | Mode switch was pending at the trap |
| core_cause | output | 5 | Processor status cause bits |
| ext_cause | output | 3 | Extended status cause bits |
| bus_in_super | output | 1 | Parity or bus error trapped at supervisor level |

## Verification
The hardest case to reach from the ports is a masked repeat error. It needs a sticky parity or bus latch to be set, the redirect to be acknowledged, and then the same error raised again, both with and without an intervening clear of only one of the two latches. The stimulus does this in a fixed order: a parity trap, a masked parity repeat, a bus trap taken on top of the held parity latch, a masked bus repeat, a bus-only clear, and then re-triggering. A sweep over all 31 non-empty combinations of the processor-side causes, crossed with both issue modes and both mode-switch values, covers cause merging and address alignment.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CORE_N = 5;
  localparam int EXT_N  = 3;

  // LSB first: instruction, external, fetch, data, floating-point
  typedef struct packed {
    logic fp;
    logic data;
    logic fetch;
    logic ext;
    logic instr;
  } core_cause_t;

  // LSB first: interrupt, parity latch, bus latch
  typedef struct packed {
    logic bus;
    logic par;
    logic irq;
  } ext_cause_t;
endpackage

// File: rtl/trap_detect.sv
module trap_detect
  import trap_pkg::*;
(
  input  logic        busy,
  input  logic        flt_instr,
  input  logic        flt_fetch,
  input  logic        flt_data,
  input  logic        flt_fp,
  input  logic        irq,
  input  logic        irq_en,
  input  logic        par_err,
  input  logic        par_en,
  input  logic        bus_err,
  input  logic        supervisor,
  input  logic        par_lat,
  input  logic        bus_lat,
  output logic        take,
  output core_cause_t core_set,
  output ext_cause_t  ext_hit,
  output logic        bs_set
);
  logic irq_ok, par_ok, bus_ok;

  always_comb begin
    irq_ok = irq & irq_en;
    par_ok = par_err & par_en & ~par_lat;
    bus_ok = bus_err & ~bus_lat;

    core_set.instr = flt_instr;
    core_set.ext   = irq_ok | par_ok | bus_ok;
    core_set.fetch = flt_fetch;
    core_set.data  = flt_data;
    core_set.fp    = flt_fp;

    ext_hit.irq = irq_ok;
    ext_hit.par = par_ok;
    ext_hit.bus = bus_ok;

    bs_set = supervisor & (par_ok | bus_ok);
    take   = ~busy & (|core_set);
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  core_cause_t       core_set,
  input  ext_cause_t        ext_hit,
  input  logic              bs_set,
  input  logic              dual_mode,
  input  logic              mode_change,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              clr_wr,
  input  logic [1:0]        clr_sel,
  output core_cause_t       core_q,
  output ext_cause_t        ext_q,
  output logic [ADDR_W-1:0] fir_q,
  output logic              dim_q,
  output logic              ds_q,
  output logic              bs_q
);
  localparam int WORD_LSB = $clog2(INSTR_BYTES);
  localparam int PAIR_LSB = WORD_LSB + 1;

  core_cause_t       core_n;
  ext_cause_t        ext_n;
  logic [ADDR_W-1:0] fir_n, pc_word, pc_pair;
  logic              dim_n, ds_n, bs_n;
  logic              clr_par, clr_bus;

  always_comb begin
    pc_word = {cur_pc[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
    pc_pair = {cur_pc[ADDR_W-1:PAIR_LSB], {PAIR_LSB{1'b0}}};
    clr_par = clr_wr & clr_sel[0];
    clr_bus = clr_wr & clr_sel[1];

    core_n    = take ? core_set : core_q;
    ext_n.irq = take ? ext_hit.irq : ext_q.irq;
    ext_n.par = (ext_q.par & ~clr_par) | (take & ext_hit.par);
    ext_n.bus = (ext_q.bus & ~clr_bus) | (take & ext_hit.bus);
    fir_n     = take ? (dual_mode ? pc_pair : pc_word) : fir_q;
    dim_n     = take ? dual_mode   : dim_q;
    ds_n      = take ? mode_change : ds_q;
    bs_n      = take ? bs_set      : bs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      ext_q  <= '0;
      fir_q  <= '0;
      dim_q  <= 1'b0;
      ds_q   <= 1'b0;
      bs_q   <= 1'b0;
    end else begin
      core_q <= core_n;
      ext_q  <= ext_n;
      fir_q  <= fir_n;
      dim_q  <= dim_n;
      ds_q   <= ds_n;
      bs_q   <= bs_n;
    end
  end
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic ack,
  output logic busy,
  output logic req_q,
  output logic flush_q
);
  logic boot_q;
  logic boot_n, req_n, flush_n;

  always_comb begin
    boot_n  = 1'b0;
    flush_n = boot_q | take;
    req_n   = boot_q | take | (req_q & ~ack);
    busy    = boot_q | req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      req_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      boot_q  <= boot_n;
      req_q   <= req_n;
      flush_q <= flush_n;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] VECTOR    = 32'hFFFF_FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_instr,
  input  logic              flt_fetch,
  input  logic              flt_data,
  input  logic              flt_fp,
  input  logic              irq,
  input  logic              irq_en,
  input  logic              par_err,
  input  logic              par_en,
  input  logic              bus_err,
  input  logic              dual_mode,
  input  logic              mode_change,
  input  logic              supervisor,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              clr_wr,
  input  logic [1:0]        clr_sel,
  input  logic              redirect_ack,
  output logic              redirect_req,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              flush,
  output logic [ADDR_W-1:0] fir,
  output logic              dim,
  output logic              ds,
  output logic [CORE_N-1:0] core_cause,
  output logic [EXT_N-1:0]  ext_cause,
  output logic              bus_in_super
);
  logic        busy, take, bs_set;
  core_cause_t core_set, core_q;
  ext_cause_t  ext_hit, ext_q;

  trap_detect u_detect (
    .busy(busy), .flt_instr(flt_instr), .flt_fetch(flt_fetch),
    .flt_data(flt_data), .flt_fp(flt_fp), .irq(irq), .irq_en(irq_en),
    .par_err(par_err), .par_en(par_en), .bus_err(bus_err),
    .supervisor(supervisor), .par_lat(ext_q.par), .bus_lat(ext_q.bus),
    .take(take), .core_set(core_set), .ext_hit(ext_hit), .bs_set(bs_set)
  );

  trap_status #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .core_set(core_set),
    .ext_hit(ext_hit), .bs_set(bs_set), .dual_mode(dual_mode),
    .mode_change(mode_change), .cur_pc(cur_pc), .clr_wr(clr_wr),
    .clr_sel(clr_sel), .core_q(core_q), .ext_q(ext_q), .fir_q(fir),
    .dim_q(dim), .ds_q(ds), .bs_q(bus_in_super)
  );

  trap_redirect u_redirect (
    .clk(clk), .rst_n(rst_n), .take(take), .ack(redirect_ack),
    .busy(busy), .req_q(redirect_req), .flush_q(flush)
  );

  assign redirect_pc = VECTOR;
  assign core_cause  = core_q;
  assign ext_cause   = ext_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redirect_req,
  input logic              redirect_ack,
  input logic              flush,
  input logic [ADDR_W-1:0] fir,
  input logic [4:0]        core_cause,
  input logic [2:0]        ext_cause,
  input logic              dim,
  input logic              clr_wr,
  input logic [1:0]        clr_sel
);
  localparam int PAIR_LSB = $clog2(INSTR_BYTES) + 1;

  // R2
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R2
  flush_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redirect_req);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_req && !redirect_ack |=> redirect_req);

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_req && redirect_ack |=> !redirect_req);

  // R4
  busy_fir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_req |=> $stable(fir) && $stable(core_cause));

  // R5
  dual_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dim |-> fir[PAIR_LSB-1:0] == '0);

  // R10
  bus_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cause[2] && !(clr_wr && clr_sel[1]) |=> ext_cause[2]);

  // R9
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cause[1] && !(clr_wr && clr_sel[0]) |=> ext_cause[1]);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect_req(redirect_req),
  .redirect_ack(redirect_ack), .flush(flush), .fir(fir),
  .core_cause(core_cause), .ext_cause(ext_cause), .dim(dim),
  .clr_wr(clr_wr), .clr_sel(clr_sel)
);

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;
  logic        clk, rst_n;
  logic        flt_instr, flt_fetch, flt_data, flt_fp;
  logic        irq, irq_en, par_err, par_en, bus_err;
  logic        dual_mode, mode_change, supervisor;
  logic [31:0] cur_pc;
  logic        clr_wr;
  logic [1:0]  clr_sel;
  logic        redirect_ack;
  logic        redirect_req, flush, dim, ds, bus_in_super;
  logic [31:0] redirect_pc, fir;
  logic [4:0]  core_cause;
  logic [2:0]  ext_cause;

  int n_chk = 0;
  int n_err = 0;

  trap_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flt_instr(flt_instr), .flt_fetch(flt_fetch),
    .flt_data(flt_data), .flt_fp(flt_fp), .irq(irq), .irq_en(irq_en),
    .par_err(par_err), .par_en(par_en), .bus_err(bus_err),
    .dual_mode(dual_mode), .mode_change(mode_change), .supervisor(supervisor),
    .cur_pc(cur_pc), .clr_wr(clr_wr), .clr_sel(clr_sel),
    .redirect_ack(redirect_ack), .redirect_req(redirect_req),
    .redirect_pc(redirect_pc), .flush(flush), .fir(fir), .dim(dim), .ds(ds),
    .core_cause(core_cause), .ext_cause(ext_cause), .bus_in_super(bus_in_super)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    flt_instr = 0; flt_fetch = 0; flt_data = 0; flt_fp = 0;
    irq = 0; par_err = 0; bus_err = 0;
  endtask

  // drive for one edge; returns at the following negedge with outputs settled
  task automatic pulse(input logic [4:0] m, input logic pe, input logic pen,
                       input logic be, input logic dm, input logic sw,
                       input logic sup, input logic [31:0] pc);
    flt_instr = m[0]; irq = m[1]; flt_fetch = m[2]; flt_data = m[3]; flt_fp = m[4];
    par_err = pe; par_en = pen; bus_err = be;
    dual_mode = dm; mode_change = sw; supervisor = sup; cur_pc = pc;
    @(negedge clk);
    clear_faults();
  endtask

  task automatic ack_it();
    redirect_ack = 1;
    @(negedge clk);
    redirect_ack = 0;
    chk("R3", "req after ack", {31'b0, redirect_req}, 32'd0);
    chk("R2", "flush after pulse", {31'b0, flush}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; clear_faults();
    irq_en = 1; par_en = 0; dual_mode = 0; mode_change = 0; supervisor = 0;
    cur_pc = '0; clr_wr = 0; clr_sel = 0; redirect_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset entry
    chk("R1", "req", {31'b0, redirect_req}, 32'd1);
    chk("R1", "flush", {31'b0, flush}, 32'd1);
    chk("R1", "vector", redirect_pc, 32'hFFFF_FF00);
    chk("R1", "core", {27'b0, core_cause}, 32'd0);
    chk("R1", "ext", {29'b0, ext_cause}, 32'd0);
    chk("R1", "dim/ds/bs", {29'b0, dim, ds, bus_in_super}, 32'd0);
    // R4: faults ignored while reset redirect pending
    pulse(5'b11111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5677);
    chk("R2", "flush one cycle", {31'b0, flush}, 32'd0);
    chk("R4", "core unchanged", {27'b0, core_cause}, 32'd0);
    chk("R4", "fir unchanged", fir, 32'd0);
    chk("R4", "ext unchanged", {29'b0, ext_cause}, 32'd0);
    chk("R3", "req held", {31'b0, redirect_req}, 32'd1);
    ack_it();

    // no conditions -> no trap
    pulse(5'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R2", "idle no flush", {31'b0, flush}, 32'd0);

    // R7/R5/R6/R8 sweep of processor-side causes
    for (int m = 1; m < 32; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] pc, efir;
          pc = 32'h4000_0000 | (m << 8) | (d << 6) | (s << 5) | (m & 7);
          efir = (d != 0) ? (pc & ~32'd7) : (pc & ~32'd3);
          pulse(m[4:0], 1'b0, 1'b0, 1'b0, d[0], s[0], 1'b0, pc);
          chk("R2", "flush", {31'b0, flush}, 32'd1);
          chk("R2", "req", {31'b0, redirect_req}, 32'd1);
          chk("R7", "core", {27'b0, core_cause}, {27'b0, m[4:0]});
          chk("R8", "ext irq", {29'b0, ext_cause}, {29'b0, 2'b0, m[1]});
          chk("R5", "fir", fir, efir);
          chk("R6", "dim", {31'b0, dim}, {31'b0, d[0]});
          chk("R6", "ds", {31'b0, ds}, {31'b0, s[0]});
          ack_it();
        end
      end
    end

    // R8: interrupt disabled
    irq_en = 0;
    pulse(5'b00010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h10);
    chk("R8", "masked irq flush", {31'b0, flush}, 32'd0);
    irq_en = 1;

    // R9: parity without enable
    pulse(5'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h20);
    chk("R9", "parity disabled", {31'b0, flush}, 32'd0);
    // R9/R11: parity in supervisor
    pulse(5'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h24);
    chk("R9", "parity flush", {31'b0, flush}, 32'd1);
    chk("R9", "core ext", {27'b0, core_cause}, 32'd2);
    chk("R9", "ext par", {29'b0, ext_cause}, 32'd2);
    chk("R11", "bs super", {31'b0, bus_in_super}, 32'd1);
    ack_it();
    // R9: repeat masked
    pulse(5'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h28);
    chk("R9", "parity masked", {31'b0, flush}, 32'd0);
    chk("R9", "par latch held", {29'b0, ext_cause}, 32'd2);
    // R10/R11: bus error at user level
    pulse(5'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2C);
    chk("R10", "bus flush", {31'b0, flush}, 32'd1);
    chk("R10", "core ext", {27'b0, core_cause}, 32'd2);
    chk("R10", "ext bus+par", {29'b0, ext_cause}, 32'd6);
    chk("R11", "bs user", {31'b0, bus_in_super}, 32'd0);
    ack_it();
    pulse(5'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h30);
    chk("R10", "bus masked", {31'b0, flush}, 32'd0);
    // R12: clear bus latch only
    clr_wr = 1; clr_sel = 2'b10;
    @(negedge clk);
    clr_wr = 0; clr_sel = 0;
    chk("R12", "bus cleared", {29'b0, ext_cause}, 32'd2);
    pulse(5'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h34);
    chk("R12", "bus retrap", {31'b0, flush}, 32'd1);
    chk("R11", "bs bus super", {31'b0, bus_in_super}, 32'd1);
    ack_it();
    // R12: clear both, parity traps again at user level
    clr_wr = 1; clr_sel = 2'b11;
    @(negedge clk);
    clr_wr = 0; clr_sel = 0;
    chk("R12", "both cleared", {29'b0, ext_cause}, 32'd0);
    pulse(5'b00001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h38);
    chk("R12", "parity retrap", {31'b0, flush}, 32'd1);
    chk("R7", "instr+ext", {27'b0, core_cause}, 32'd3);
    chk("R11", "bs user parity", {31'b0, bus_in_super}, 32'd0);
    // R3: no ack for several cycles
    repeat (3) @(negedge clk);
    chk("R3", "req held no ack", {31'b0, redirect_req}, 32'd1);
    ack_it();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule